// File: doc/BRIEF.md
# Dual-Line Interrupt Status Register

This block gathers single-cycle event pulses from a serial-bus remote terminal and records them in a sticky pending-status word. The host can only read this word. An enable word, which the host writes elsewhere, decides which events are recorded. Two fault events, address-parity failure and configuration-checksum failure, are always recorded, whatever the enable word holds. Once an event is latched it stays set until the host reads the word and raises the read-clear strobe in the same cycle.

The latched bits drive two host interrupt lines, sorted by category. One line carries message events: message error, illegal command, and loopback failure on bus A or bus B. The other line carries hardware events: host serial-interface failure, time-tag match, time-tag rollover, address-parity failure and checksum failure.

Each clock cycle in which at least one new bit becomes set produces a one-cycle log-write strobe. The strobe carries the vector of the bits that were newly set in that cycle. The log sink cannot push back: it must take the strobe in every cycle that it appears, so the strobe has no ready input.

Top module: `irq_status_top`

## Requirements
- R1: After reset the status word, both interrupt lines and the log strobe are all zero.
- R2: The status bit positions are fixed: message error is bit 10, illegal command bit 8, serial-interface failure bit 7, bus A loopback failure bit 6, bus B loopback failure bit 5, time-tag match bit 4, time-tag rollover bit 3, address-parity failure bit 2 and checksum failure bit 1. Event and enable inputs use the same positions. Bits 9 and 0 always read zero, whatever arrives on their event or enable inputs.
- R3: An event at bits 10 or 8 to 3 whose enable bit is 1 sets its status bit at the next clock edge. That bit stays set in every following cycle until a clear.
- R4: An event at bits 10 or 8 to 3 whose enable bit is 0 leaves the status word unchanged.
- R5: An event at bit 2 or bit 1 latches even when its enable bit is 0.
- R6: When the read-clear strobe is high at a clock edge, every latched bit is cleared at that edge. An event that qualifies in the same cycle is still latched.
- R7: The message interrupt line is high exactly when any of status bits 10, 8, 6 or 5 is set.
- R8: The hardware interrupt line is high exactly when any of status bits 7, 4, 3, 2 or 1 is set.
- R9: The log strobe is high for the one cycle that follows a clock edge at which some qualifying event hit a status bit that was clear before that edge. The log vector then holds exactly those bits. An event on a bit that is already set produces no strobe, and this holds even in a clear cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 11 | Event pulses, one per status position |
| en_i | input | 11 | Host enable word, one bit per status position |
| rd_clr_i | input | 1 | Read-clear strobe |
| status_o | output | 11 | Pending-status word |
| irq_msg_o | output | 1 | Message-category interrupt |
| irq_hw_o | output | 1 | Hardware-category interrupt |
| log_valid_o | output | 1 | Log-write strobe |
| log_bits_o | output | 11 | Newly latched bits for the log |

## Verification
The assertions take for granted that the event and enable inputs are known and stable across each rising edge, and that they are held at zero during reset. With that in place, any past value they sample is meaningful once reset has ended. The stimulus changes inputs only on falling edges and keeps them at zero during reset. It mixes directed patterns, including events that arrive together with a clear, events on the unused positions, and disabled events, with a long random phase. In that phase the enable words, the event vectors and the clear strobes are all drawn at random, so that clears and repeat events on bits that are already set occur often.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STAT_W = 11;

  localparam int B_MSG_ERR   = 10;
  localparam int B_ILL_CMD   = 8;
  localparam int B_HOST_FAIL = 7;
  localparam int B_LOOP_A    = 6;
  localparam int B_LOOP_B    = 5;
  localparam int B_TT_MATCH  = 4;
  localparam int B_TT_ROLL   = 3;
  localparam int B_ADDR_PAR  = 2;
  localparam int B_CKSUM     = 1;

  localparam logic [STAT_W-1:0] MSG_MASK =
    (STAT_W'(1) << B_MSG_ERR) | (STAT_W'(1) << B_ILL_CMD) |
    (STAT_W'(1) << B_LOOP_A)  | (STAT_W'(1) << B_LOOP_B);

  localparam logic [STAT_W-1:0] HW_MASK =
    (STAT_W'(1) << B_HOST_FAIL) | (STAT_W'(1) << B_TT_MATCH) |
    (STAT_W'(1) << B_TT_ROLL)   | (STAT_W'(1) << B_ADDR_PAR) |
    (STAT_W'(1) << B_CKSUM);

  localparam logic [STAT_W-1:0] FORCE_MASK =
    (STAT_W'(1) << B_ADDR_PAR) | (STAT_W'(1) << B_CKSUM);

  localparam logic [STAT_W-1:0] LIVE_MASK = MSG_MASK | HW_MASK;
endpackage

// File: rtl/irq_evt_gate.sv
module irq_evt_gate #(
  parameter int W = 11,
  parameter logic [W-1:0] LIVE  = '1,
  parameter logic [W-1:0] FORCE = '0
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] hit_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // A position qualifies when it is live and either enabled or forced on.
    assign hit_o[i] = evt_i[i] & (en_i[i] | FORCE[i]) & LIVE[i];
  end
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] fresh_o
);
  logic [W-1:0] stat_q;

  // Bits that were clear before this edge and are hit now; a clear does not
  // make an already-set bit fresh.
  assign fresh_o = hit_i & ~stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (clr_i ? '0 : stat_q) | hit_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_line_or.sv
module irq_line_or #(
  parameter int W = 11,
  parameter logic [W-1:0] SEL = '1
) (
  input  logic [W-1:0] stat_i,
  output logic         irq_o
);
  assign irq_o = |(stat_i & SEL);
endmodule

// File: rtl/irq_log_pulse.sv
module irq_log_pulse #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fresh_i,
  output logic         valid_o,
  output logic [W-1:0] bits_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      bits_o  <= '0;
    end else begin
      valid_o <= |fresh_i;
      bits_o  <= fresh_i;
    end
  end
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] en_i,
  input  logic              rd_clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_msg_o,
  output logic              irq_hw_o,
  output logic              log_valid_o,
  output logic [STAT_W-1:0] log_bits_o
);
  logic [STAT_W-1:0] hit;
  logic [STAT_W-1:0] fresh;

  irq_evt_gate #(.W(STAT_W), .LIVE(LIVE_MASK), .FORCE(FORCE_MASK)) u_gate (
    .evt_i(evt_i), .en_i(en_i), .hit_o(hit)
  );

  irq_sticky_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(rd_clr_i),
    .stat_o(status_o), .fresh_o(fresh)
  );

  irq_line_or #(.W(STAT_W), .SEL(MSG_MASK)) u_msg_line (
    .stat_i(status_o), .irq_o(irq_msg_o)
  );

  irq_line_or #(.W(STAT_W), .SEL(HW_MASK)) u_hw_line (
    .stat_i(status_o), .irq_o(irq_hw_o)
  );

  irq_log_pulse #(.W(STAT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .fresh_i(fresh),
    .valid_o(log_valid_o), .bits_o(log_bits_o)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] evt_i,
  input logic [STAT_W-1:0] en_i,
  input logic              rd_clr_i,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_msg_o,
  input logic              irq_hw_o,
  input logic              log_valid_o,
  input logic [STAT_W-1:0] log_bits_o
);
  localparam logic [STAT_W-1:0] DEAD =
    (STAT_W'(1) << 9) | STAT_W'(1);

  logic [STAT_W-1:0] qual;
  assign qual = evt_i & (en_i | FORCE_MASK) & LIVE_MASK;

  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & DEAD) == '0); // R2

  AST_QUAL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    qual != '0 |=> (status_o & $past(qual)) == $past(qual)); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> (status_o & $past(status_o)) == $past(status_o)); // R3

  AST_NO_UNQUAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o & ~$past(status_o) & ~$past(qual)) == '0); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> status_o == $past(qual)); // R6

  AST_MSG_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_o == ((status_o & MSG_MASK) != '0)); // R7

  AST_HW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hw_o == ((status_o & HW_MASK) != '0)); // R8

  AST_LOG_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> log_bits_o == ($past(qual) & ~$past(status_o))); // R9

  AST_LOG_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid_o == (log_bits_o != '0)); // R9
endmodule

bind irq_status_top irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .rd_clr_i(rd_clr_i),
  .status_o(status_o), .irq_msg_o(irq_msg_o), .irq_hw_o(irq_hw_o),
  .log_valid_o(log_valid_o), .log_bits_o(log_bits_o)
);

// File: tb/irq_status_top_bench.sv
module irq_status_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt_i = '0;
  logic [10:0] en_i = '0;
  logic        rd_clr_i = 1'b0;
  logic [10:0] status_o;
  logic        irq_msg_o, irq_hw_o, log_valid_o;
  logic [10:0] log_bits_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state, from the requirements.
  logic [10:0] m_stat = '0;
  logic        m_lv = 1'b0;
  logic [10:0] m_lb = '0;
  bit          cmp_on = 0;

  always #10 clk = ~clk;

  irq_status_top u_irq_status_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .rd_clr_i(rd_clr_i),
    .status_o(status_o), .irq_msg_o(irq_msg_o), .irq_hw_o(irq_hw_o),
    .log_valid_o(log_valid_o), .log_bits_o(log_bits_o)
  );

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model update: bits 10 and 8..1 are live; 2 and 1 are always enabled.
  always @(posedge clk) begin
    logic [10:0] q, nw;
    if (!rst_n) begin
      m_stat = '0; m_lv = 1'b0; m_lb = '0;
    end else begin
      q = evt_i & (en_i | 11'h006) & 11'h5FE;
      nw = q & ~m_stat;
      m_stat = (rd_clr_i ? 11'h000 : m_stat) | q;
      m_lv = (nw != 0);
      m_lb = nw;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3/R4/R5/R6 status", status_o, m_stat);
      chk("R7 msg line", {10'd0, irq_msg_o}, {10'd0, (m_stat & 11'h560) != 0});
      chk("R8 hw line", {10'd0, irq_hw_o}, {10'd0, (m_stat & 11'h09E) != 0});
      chk("R9 log strobe", {10'd0, log_valid_o}, {10'd0, m_lv});
      chk("R9 log bits", log_bits_o, m_lb);
    end
  end

  task automatic step(input logic [10:0] e, input logic [10:0] n, input logic r);
    evt_i = e; en_i = n; rd_clr_i = r;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 11'h000);
    chk("R1 lines", {9'd0, irq_msg_o, irq_hw_o}, 11'h000);
    chk("R1 log", {10'd0, log_valid_o}, 11'h000);
    cmp_on = 1;

    // R2 unused positions never latch
    step(11'h201, 11'h7FF, 1'b0);
    chk("R2 dead bits", status_o, 11'h000);
    chk("R2 no log", {10'd0, log_valid_o}, 11'h000);

    // R4 disabled events ignored
    step(11'h5F8, 11'h000, 1'b0);
    chk("R4 disabled", status_o, 11'h000);
    chk("R4 no irq", {9'd0, irq_msg_o, irq_hw_o}, 11'h000);

    // R5 forced bit 2 latches with enable off; R8 hw line
    step(11'h004, 11'h000, 1'b0);
    chk("R5 forced parity", status_o, 11'h004);
    chk("R8 hw high", {9'd0, irq_msg_o, irq_hw_o}, 11'h001);
    chk("R9 log bits", log_bits_o, 11'h004);

    // R6 clear empties, R8 hw line drops
    step(11'h000, 11'h000, 1'b1);
    chk("R6 cleared", status_o, 11'h000);
    chk("R8 hw low", {10'd0, irq_hw_o}, 11'h000);

    // R3/R7 enabled message error latches and sticks
    step(11'h400, 11'h7FF, 1'b0);
    chk("R3 latch", status_o, 11'h400);
    chk("R7 msg high", {9'd0, irq_msg_o, irq_hw_o}, 11'h002);
    chk("R9 strobe", {10'd0, log_valid_o}, 11'h001);
    step(11'h000, 11'h7FF, 1'b0);
    chk("R3 sticky", status_o, 11'h400);
    chk("R9 single pulse", {10'd0, log_valid_o}, 11'h000);

    // R9 repeat event on a set bit: no strobe
    step(11'h400, 11'h7FF, 1'b0);
    chk("R9 repeat", {10'd0, log_valid_o}, 11'h000);

    // R6 event with clear stays latched; R9 set bit in clear cycle not logged
    step(11'h440, 11'h7FF, 1'b1);
    chk("R6 event during clear", status_o, 11'h440);
    chk("R9 clear-cycle log", log_bits_o, 11'h040);

    // Random phase with per-cycle model comparison.
    for (int i = 0; i < 3000; i++) begin
      step($urandom() & 11'h7FF, $urandom() & 11'h7FF, ($urandom() % 6) == 0);
    end
    step(11'h000, 11'h000, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule